// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits beside a direct-mapped first-level cache and keeps the lines that cache has recently displaced. Every lookup that reaches the first-level arrays is also presented here in the same cycle. The match, the stored line and its dirty flag come back combinationally, so a hit here costs no more time than a first-level hit. A hit means the block has to go back into the first-level cache, so the matching entry leaves the buffer at the next clock edge.

When the first-level cache pushes out a line, it offers that line on the insert port. If a lookup hits in the same cycle, the two lines trade places: the displaced first-level line is written into the slot the returning line vacates, in one cycle and with no eviction. Any other insert takes the lowest-numbered empty slot. When no slot is empty, it overwrites the least recently filled entry. A dirty entry pushed out this way is reported one cycle later on the write-back port toward the next level. A clean one is dropped.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is empty: no lookup hits and the write-back valid output is low.
- R2: A lookup with `lookupValid` high for a stored block raises `lookupHit` in the same cycle, with that block's line on `lookupLine` and its dirty flag on `lookupDirty`.
- R3: A lookup for a block not stored, or any cycle with `lookupValid` low, gives `lookupHit` low.
- R4: A hit while `insertValid` is high is a swap: after the edge the returned block no longer hits, the inserted block hits with its own line and dirty flag, and no write-back occurs.
- R5: A hit with `insertValid` low frees that entry: the block no longer hits, and the next insert fills the freed slot without any write-back.
- R6: An insert without a hit into a full buffer removes the entry filled or swapped least recently. If that entry was dirty, `wbValid` is high in the cycle after the insert edge, with its block on `wbBlock` and its line on `wbLine`. A clean entry is removed without a write-back.
- R7: While an empty slot exists, an insert removes no entry and produces no write-back.
- R8: A swap counts as a fresh fill for recency, so a swapped-in line is the last of the current entries to be chosen for removal.
- R9: `wbValid` stays high for exactly one cycle per dirty removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupBlock | input | BLK_W | Block number being looked up |
| lookupHit | output | 1 | Block found in the buffer (same cycle) |
| lookupLine | output | LINE_W | Line data of the hitting entry |
| lookupDirty | output | 1 | Dirty flag of the hitting entry |
| insertValid | input | 1 | A line displaced from the first-level cache is offered |
| insertBlock | input | BLK_W | Block number of the offered line |
| insertLine | input | LINE_W | Data of the offered line |
| insertDirty | input | 1 | Offered line is modified |
| wbValid | output | 1 | One-cycle pulse: a dirty entry was pushed out |
| wbBlock | output | BLK_W | Block number of the pushed-out entry |
| wbLine | output | LINE_W | Data of the pushed-out entry |

## Verification
The bench fills the buffer and then does a swap in the oldest slot. It then fills further so the removal choice shows whether the swap refreshed recency: a design that did not refresh it would push out the swapped-back block early. Clean and dirty removals are both exercised. A design that reported every removal, or kept the pulse high for two cycles, gets caught. A hit without an insert is followed by a fill that must reuse the freed slot quietly, which exposes a design that evicts while a slot is empty. A lookup with its valid low on a stored block and a reset after activity guard against stale hits.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Strobes from the control to the storage datapath.
  typedef struct packed {
    logic wrEn;     // write the offered line into slot wrIdx
    logic clrEn;    // invalidate slot clrIdx (line returned to L1)
    logic spillEn;  // slot wrIdx held a valid entry that is being pushed out
  } vcStrobe_t;
endpackage

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int DEPTH = 4,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touchEn,
  input  logic [IDX_W-1:0] touchIdx,
  output logic [IDX_W-1:0] lruIdx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(DEPTH - 1);

  // Ages form a permutation of 0..DEPTH-1; 0 is most recent.
  logic [IDX_W-1:0] age [DEPTH];
  logic [DEPTH-1:0] oldestVec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == touchIdx)      age[i] <= '0;
        else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lruIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      oldestVec[i] = (age[i] == OLDEST);
      if (oldestVec[i]) lruIdx = IDX_W'(i);
    end
  end

  // Recency order must always name exactly one oldest slot (R6).
  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldestVec) == 1)
    else $error("more or fewer than one oldest slot");
endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BLK_W  = 26,
  parameter int LINE_W = 64,
  parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  lookupBlock,
  input  logic [BLK_W-1:0]  insertBlock,
  input  logic [LINE_W-1:0] insertLine,
  input  logic              insertDirty,
  input  vcStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  clrIdx,
  output logic              hitAny,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [LINE_W-1:0] hitLine,
  output logic              hitDirty,
  output logic              freeAny,
  output logic [IDX_W-1:0]  freeIdx,
  output logic              wbValid,
  output logic [BLK_W-1:0]  wbBlock,
  output logic [LINE_W-1:0] wbLine
);
  logic [DEPTH-1:0]  validVec;
  logic [DEPTH-1:0]  dirtyVec;
  logic [BLK_W-1:0]  tagArr  [DEPTH];
  logic [LINE_W-1:0] lineArr [DEPTH];
  logic [DEPTH-1:0]  hitVec;

  // One comparator per entry.
  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign hitVec[g] = validVec[g] && (tagArr[g] == lookupBlock);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hitVec[i]) hitIdx = IDX_W'(i);
    hitAny   = |hitVec;
    hitLine  = lineArr[hitIdx];
    hitDirty = dirtyVec[hitIdx];
  end

  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IDX_W'(i);
    freeAny = ~&validVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validVec <= '0;
      dirtyVec <= '0;
    end else begin
      if (strobe.clrEn) validVec[clrIdx] <= 1'b0;
      if (strobe.wrEn) begin
        validVec[wrIdx] <= 1'b1;
        dirtyVec[wrIdx] <= insertDirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagArr[wrIdx]  <= insertBlock;
      lineArr[wrIdx] <= insertLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbValid <= 1'b0;
      wbBlock <= '0;
      wbLine  <= '0;
    end else begin
      wbValid <= strobe.spillEn && dirtyVec[wrIdx];
      if (strobe.spillEn) begin
        wbBlock <= tagArr[wrIdx];
        wbLine  <= lineArr[wrIdx];
      end
    end
  end

  // Stored blocks are unique, so at most one comparator fires (R2).
  assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec))
    else $error("several entries match one block");

  // A push-out is only requested when every slot is occupied (R7).
  assert_spill_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.spillEn |-> (&validVec))
    else $error("entry pushed out while a slot is empty");

  // A non-spilling write lands in an empty slot or the slot being swapped (R4).
  assert_write_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && !strobe.spillEn) |-> (!validVec[wrIdx] || hitVec[wrIdx]))
    else $error("write overwrote a live entry without push-out");
endmodule

// File: rtl/vc_control.sv
module vc_control
  import vc_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             lookupValid,
  input  logic             hitAny,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic             insertValid,
  input  logic             freeAny,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic [IDX_W-1:0] lruIdx,
  output vcStrobe_t        strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] clrIdx,
  output logic             touchEn,
  output logic             lookupHit
);
  logic swapHit;

  always_comb begin
    swapHit        = lookupValid && hitAny;
    strobe         = '0;
    wrIdx          = freeIdx;
    clrIdx         = hitIdx;
    if (swapHit) begin
      wrIdx = hitIdx;
      if (insertValid) strobe.wrEn  = 1'b1;  // trade places in one cycle
      else             strobe.clrEn = 1'b1;  // line simply returns to L1
    end else if (insertValid) begin
      strobe.wrEn = 1'b1;
      if (!freeAny) begin
        wrIdx          = lruIdx;
        strobe.spillEn = 1'b1;
      end
    end
    touchEn   = strobe.wrEn;
    lookupHit = swapHit;
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BLK_W  = 26,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [BLK_W-1:0]  lookupBlock,
  output logic              lookupHit,
  output logic [LINE_W-1:0] lookupLine,
  output logic              lookupDirty,
  input  logic              insertValid,
  input  logic [BLK_W-1:0]  insertBlock,
  input  logic [LINE_W-1:0] insertLine,
  input  logic              insertDirty,
  output logic              wbValid,
  output logic [BLK_W-1:0]  wbBlock,
  output logic [LINE_W-1:0] wbLine
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  vcStrobe_t        strobe;
  logic [IDX_W-1:0] wrIdx, clrIdx, hitIdx, freeIdx, lruIdx;
  logic             hitAny, freeAny, touchEn;

  vc_datapath #(.DEPTH(DEPTH), .BLK_W(BLK_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rst_n(rst_n),
    .lookupBlock(lookupBlock),
    .insertBlock(insertBlock), .insertLine(insertLine), .insertDirty(insertDirty),
    .strobe(strobe), .wrIdx(wrIdx), .clrIdx(clrIdx),
    .hitAny(hitAny), .hitIdx(hitIdx), .hitLine(lookupLine), .hitDirty(lookupDirty),
    .freeAny(freeAny), .freeIdx(freeIdx),
    .wbValid(wbValid), .wbBlock(wbBlock), .wbLine(wbLine)
  );

  vc_control #(.IDX_W(IDX_W)) uCtrl (
    .lookupValid(lookupValid), .hitAny(hitAny), .hitIdx(hitIdx),
    .insertValid(insertValid), .freeAny(freeAny), .freeIdx(freeIdx),
    .lruIdx(lruIdx), .strobe(strobe), .wrIdx(wrIdx), .clrIdx(clrIdx),
    .touchEn(touchEn), .lookupHit(lookupHit)
  );

  vc_lru #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uLru (
    .clk(clk), .rst_n(rst_n),
    .touchEn(touchEn), .touchIdx(wrIdx), .lruIdx(lruIdx)
  );

  // A block returned to L1 without a swap must not hit again next cycle (R5).
  assert_gone_after_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && lookupHit && !insertValid) |=>
      !(lookupValid && lookupHit && (lookupBlock == $past(lookupBlock))))
    else $error("returned block still hits");
endmodule

// File: tb/tb_victim_cache.sv
module tb_victim_cache;
  localparam int DEPTH  = 4;
  localparam int BLK_W  = 26;
  localparam int LINE_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lookupValid = 1'b0;
  logic [BLK_W-1:0]  lookupBlock = '0;
  logic              lookupHit;
  logic [LINE_W-1:0] lookupLine;
  logic              lookupDirty;
  logic              insertValid = 1'b0;
  logic [BLK_W-1:0]  insertBlock = '0;
  logic [LINE_W-1:0] insertLine = '0;
  logic              insertDirty = 1'b0;
  logic              wbValid;
  logic [BLK_W-1:0]  wbBlock;
  logic [LINE_W-1:0] wbLine;

  int testCount = 0;
  int failCount = 0;
  int cycles    = 0;

  victim_cache #(.DEPTH(DEPTH), .BLK_W(BLK_W), .LINE_W(LINE_W)) dut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic       lkV;
    logic [7:0] lkBlk;
    logic       insV;
    logic [7:0] insBlk;
    logic       insDirty;
    logic       expHit;
    logic       expDirty;
    logic       expWb;
    logic [7:0] expWbBlk;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 0  R3 absent
    '{1'b0, 8'h00, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // 1  R7 fill
    '{1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 2  R7
    '{1'b0, 8'h00, 1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // 3  R7
    '{1'b0, 8'h00, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 4  R7 now full
    '{1'b1, 8'h11, 1'b1, 8'h55, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // 5  R4 swap
    '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 6  R4 gone
    '{1'b1, 8'h55, 1'b1, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // 7  R8 swap back
    '{1'b0, 8'h00, 1'b1, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 8  R6 clean 22 out
    '{1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 9  R6 22 gone
    '{1'b0, 8'h00, 1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33}, // 10 R6 dirty 33 out
    '{1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 11 R9 pulse ends
    '{1'b1, 8'h44, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // 12 R5 return
    '{1'b1, 8'h44, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 13 R5 gone
    '{1'b0, 8'h00, 1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 14 R5 reuse slot
    '{1'b0, 8'h00, 1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11}, // 15 R8 oldest is 11
    '{1'b0, 8'h77, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // 16 R3 valid low
    '{1'b1, 8'h66, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}  // 17 R2 clean hit
  };

  function automatic logic [LINE_W-1:0] lineOf(input logic [7:0] b);
    return {8'hC3, b, 16'h0000, ~b, 8'h5A, b ^ 8'h3C, 8'h96};
  endfunction

  function automatic string reqOf(input int s);
    case (s)
      0, 16:          return "R3";
      1, 2, 3, 4, 14: return "R7";
      5, 6:           return "R4";
      7, 15:          return "R8";
      8, 9, 10:       return "R6";
      11:             return "R9";
      12, 13:         return "R5";
      default:        return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    lookupValid = 1'b1;
    lookupBlock = BLK_W'(8'h11);
    #1;
    check(lookupHit == 1'b0, "R1", "hit after reset", LINE_W'(lookupHit), 0);
    check(wbValid == 1'b0, "R1", "wbValid after reset", LINE_W'(wbValid), 0);

    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      lookupValid = STEPS[s].lkV;
      lookupBlock = BLK_W'(STEPS[s].lkBlk);
      insertValid = STEPS[s].insV;
      insertBlock = BLK_W'(STEPS[s].insBlk);
      insertLine  = lineOf(STEPS[s].insBlk);
      insertDirty = STEPS[s].insDirty;
      #1;
      check(lookupHit == STEPS[s].expHit, reqOf(s), $sformatf("step %0d hit", s),
            LINE_W'(lookupHit), LINE_W'(STEPS[s].expHit));
      if (STEPS[s].expHit) begin
        check(lookupLine == lineOf(STEPS[s].lkBlk), "R2", $sformatf("step %0d line", s),
              lookupLine, lineOf(STEPS[s].lkBlk));
        check(lookupDirty == STEPS[s].expDirty, "R2", $sformatf("step %0d dirty", s),
              LINE_W'(lookupDirty), LINE_W'(STEPS[s].expDirty));
      end
      @(posedge clk);
      #1;
      check(wbValid == STEPS[s].expWb, reqOf(s), $sformatf("step %0d wbValid", s),
            LINE_W'(wbValid), LINE_W'(STEPS[s].expWb));
      if (STEPS[s].expWb) begin
        check(wbBlock == BLK_W'(STEPS[s].expWbBlk), "R6", $sformatf("step %0d wbBlock", s),
              LINE_W'(wbBlock), LINE_W'(STEPS[s].expWbBlk));
        check(wbLine == lineOf(STEPS[s].expWbBlk), "R6", $sformatf("step %0d wbLine", s),
              wbLine, lineOf(STEPS[s].expWbBlk));
      end
    end

    // R4: the line swapped in at step 7 (block 11) was pushed out at step 15,
    // while 88 and 99 must still be present; 99 hit frees it (checked via line).
    @(negedge clk);
    insertValid = 1'b0;
    lookupValid = 1'b1;
    lookupBlock = BLK_W'(8'h99);
    #1;
    check(lookupHit == 1'b1, "R7", "block 99 present", LINE_W'(lookupHit), 1);
    check(lookupLine == lineOf(8'h99), "R2", "block 99 line", lookupLine, lineOf(8'h99));

    // R1: reset after activity empties the buffer
    @(negedge clk);
    lookupValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookupValid = 1'b1;
    lookupBlock = BLK_W'(8'h77);
    #1;
    check(lookupHit == 1'b0, "R1", "hit after second reset", LINE_W'(lookupHit), 0);
    check(wbValid == 1'b0, "R1", "wbValid after second reset", LINE_W'(wbValid), 0);

    @(negedge clk);
    lookupValid = 1'b0;
    finishRun();
  end
endmodule